// File: doc/BRIEF.md
# Bus-Width Splitting Static Memory Controller

This block lets a 32-bit host reach an asynchronous SRAM or NOR flash device whose data bus is 8 or 16 bits wide. The host offers one transfer at a time (byte, halfword or word). When the transfer is wider than the device, the block turns it into a run of narrow device cycles. It walks the device byte address upward from the aligned base, so the least significant host byte is handled first. Chip select stays low for the whole run. Write cycles get a setup phase, a write-strobe phase and an idle phase. Reads run in page style: one setup phase, then one access phase per device cycle, with output enable held low the whole time. Read bytes are gathered into their host lanes, and a single response is returned once the last device cycle has finished.

The request side is a valid/ready stream. `req_ready` is high only while the controller is idle. A request moves on the clock edge where `req_valid` and `req_ready` are both high, and the request fields are ignored on every other edge. The response side is also valid/ready. `rsp_valid` and the response fields hold steady until the edge where `rsp_ready` is high. No new request is taken while a response is waiting, so a stalled consumer pushes back all the way to the request side.

Phase lengths come from three 4-bit configuration inputs, each coding a length of value+1 clocks (1 to 16). These inputs, and the width select, must be held steady while an access is in flight. Addresses at or above `MAP_BYTES` are unmapped. The request address is aligned down to its transfer size. Only little-endian ordering is used.

Top module: `extmem_split_ctrl`

## Requirements
- R1: `req_ready` is 1 only when no access is in progress and no response is waiting. A request is taken only on an edge where both `req_valid` and `req_ready` are 1.
- R2: A mapped access of B bytes (B = 1, 2 or 4 for `req_size` 0, 1 or 2) makes B device cycles when `cfg_wide`=0. When `cfg_wide`=1 it makes B/2 cycles, or one cycle for a byte.
- R3: Device cycles go in ascending byte-address order from the base (the request address with its low bits cleared to B alignment). The address steps by 1 in 8-bit mode and by 2 in 16-bit mode. In 16-bit mode `mem_addr` bit 0 is 0.
- R4: The active-low lane mask `mem_be_n` has bit 0 for `mem_dq[7:0]` and bit 1 for `mem_dq[15:8]`. In 8-bit mode it is 2'b10. In 16-bit mode it is 2'b00 for halfword cycles, and for a byte it is 2'b10 at an even address and 2'b01 at an odd one. Write data for the device byte at address a is host byte a[1:0]. It goes on `mem_dq_out[7:0]` in 8-bit mode and on lane a[0] in 16-bit mode.
- R5: Let S, A and I be `cfg_setup`+1, `cfg_access`+1 and `cfg_idle`+1. Each write cycle has S clocks with chip select low and strobes high, then A clocks with `mem_we_n` low, then I clocks with strobes high. `mem_addr` is constant while `mem_we_n` is low. `rsp_valid` is first high right after the edge n·(S+A+I) clocks after the accepting edge.
- R6: A read has one setup of S clocks, then A clocks per device cycle. `mem_oe_n` falls exactly once and stays low until the last cycle ends. Data is sampled on the last clock of each access phase. `rsp_valid` is first high right after the edge S+n·A clocks after the accepting edge. `mem_we_n` and `mem_oe_n` are never low together.
- R7: The read byte from device address a is returned in `rsp_rdata` lane a[1:0]. Lanes the access did not cover read as zero.
- R8: `mem_cs_n` falls exactly once per mapped access and stays low across all its device cycles. No strobe is asserted while `mem_cs_n` is high.
- R9: A request with address >= `MAP_BYTES` makes no device cycle. It responds right after the accepting edge with `rsp_resp`=2'b01 and zero data. Mapped accesses respond 2'b00.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields stay stable and `req_ready` stays 0. After the edge with `rsp_ready`=1, `rsp_valid` is 0.
- R11: Right after reset, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 0: 8-bit device, 1: 16-bit device |
| cfg_setup | input | 4 | Address setup length minus one |
| cfg_access | input | 4 | Read access / write strobe length minus one |
| cfg_idle | input | 4 | Write idle length minus one |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 32 | Host byte address |
| req_wdata | input | 32 | Host write data, byte k in bits 8k+7:8k |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed on this edge when valid |
| rsp_resp | output | 2 | 2'b00 okay, 2'b01 error |
| rsp_rdata | output | 32 | Reassembled read data |
| mem_cs_n | output | 1 | Device chip select, active low |
| mem_oe_n | output | 1 | Device output enable, active low |
| mem_we_n | output | 1 | Device write enable, active low |
| mem_be_n | output | 2 | Byte-lane mask, active low |
| mem_addr | output | DEV_AW | Device byte address |
| mem_dq_out | output | 16 | Device write data |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Device read data |

## Verification
The bench sweeps every combination of device width, transfer size, low address offset and direction under three phase-length settings. Size against width separates the cycle-count rule of R2 from the lane-mask rule of R4. The offsets expose any wrong alignment or wrong lane placement, in both the write data and the reassembled read data. Changing the phase lengths separates the write schedule, which repeats setup and idle in every cycle, from the page-style read schedule, which has a single setup. Unmapped addresses at the map boundary and far above it, a 16-clock phase setting, and held-off response consumers cover the error path and back-pressure.

// File: rtl/extmem_pkg.sv
package extmem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RDACC,
    ST_WREN,
    ST_WIDLE,
    ST_RESP
  } xm_state_t;

  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] RESP_ERROR = 2'b01;
endpackage

// File: rtl/extmem_phase_timer.sv
module extmem_phase_timer #(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PH_W-1:0] load_val,
  output logic            last
);
  logic [PH_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/extmem_lane_map.sv
module extmem_lane_map #(
  parameter int DEV_AW = 16
) (
  input  logic              wide,
  input  logic [1:0]        size,
  input  logic [DEV_AW-1:0] base,
  input  logic [1:0]        idx,
  input  logic [31:0]       wdata,
  output logic [DEV_AW-1:0] dev_addr,
  output logic [1:0]        be_n,
  output logic [15:0]       dq,
  output logic [1:0]        lane,
  output logic [2:0]        num_cyc
);
  logic [1:0]        size_eff;
  logic [2:0]        offs;
  logic [DEV_AW-1:0] raw;

  always_comb begin
    size_eff = (size == 2'd3) ? 2'd2 : size;
    offs     = wide ? {idx, 1'b0} : {1'b0, idx};
    raw      = base + DEV_AW'(offs);
    lane     = raw[1:0];
    dev_addr = wide ? {raw[DEV_AW-1:1], 1'b0} : raw;

    if (!wide)                 be_n = 2'b10;
    else if (size_eff == 2'd0) be_n = raw[0] ? 2'b01 : 2'b10;
    else                       be_n = 2'b00;

    if (wide) dq = raw[1] ? wdata[31:16] : wdata[15:0];
    else begin
      case (raw[1:0])
        2'd0:    dq = {8'h00, wdata[7:0]};
        2'd1:    dq = {8'h00, wdata[15:8]};
        2'd2:    dq = {8'h00, wdata[23:16]};
        default: dq = {8'h00, wdata[31:24]};
      endcase
    end

    case (size_eff)
      2'd0:    num_cyc = 3'd1;
      2'd1:    num_cyc = wide ? 3'd1 : 3'd2;
      default: num_cyc = wide ? 3'd2 : 3'd4;
    endcase
  end
endmodule

// File: rtl/extmem_rd_gather.sv
module extmem_rd_gather (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        cap,
  input  logic        wide,
  input  logic [1:0]  be_n,
  input  logic [1:0]  lane,
  input  logic [15:0] dq_in,
  output logic [31:0] rdata
);
  logic [31:0] word_q;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic take;
    logic [7:0] src;
    always_comb begin
      if (wide) begin
        take = (lane[1] == k[1]) && !be_n[k % 2];
        src  = (k % 2 == 1) ? dq_in[15:8] : dq_in[7:0];
      end else begin
        take = (lane == k[1:0]);
        src  = dq_in[7:0];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           word_q[8*k +: 8] <= 8'h00;
      else if (clr)         word_q[8*k +: 8] <= 8'h00;
      else if (cap && take) word_q[8*k +: 8] <= src;
    end
  end

  assign rdata = word_q;
endmodule

// File: rtl/extmem_split_ctrl.sv
module extmem_split_ctrl
  import extmem_pkg::*;
#(
  parameter int          DEV_AW    = 16,
  parameter logic [31:0] MAP_BYTES = 32'h0000_C000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic [3:0]        cfg_setup,
  input  logic [3:0]        cfg_access,
  input  logic [3:0]        cfg_idle,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_resp,
  output logic [31:0]       rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [1:0]        mem_be_n,
  output logic [DEV_AW-1:0] mem_addr,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);
  localparam int PH_W = 4;

  xm_state_t         st_q, st_d;
  logic [1:0]        idx_q, idx_d;
  logic              wr_q;
  logic [1:0]        size_q;
  logic [DEV_AW-1:0] base_q;
  logic [31:0]       wdata_q;
  logic [1:0]        resp_q;

  logic              accept, hit;
  logic [DEV_AW-1:0] req_base;
  logic              tm_load, tm_last;
  logic [PH_W-1:0]   tm_val;
  logic              cap, clr;
  logic              last_cyc;

  logic [DEV_AW-1:0] cyc_addr;
  logic [1:0]        cyc_be_n, cyc_lane;
  logic [15:0]       cyc_dq;
  logic [2:0]        num_cyc;
  logic [31:0]       gathered;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hit       = (req_addr < MAP_BYTES);

  always_comb begin
    req_base = req_addr[DEV_AW-1:0];
    if (req_size != 2'd0) req_base[0] = 1'b0;
    if (req_size[1])      req_base[1] = 1'b0;
  end

  extmem_phase_timer #(.PH_W(PH_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val), .last(tm_last)
  );

  extmem_lane_map #(.DEV_AW(DEV_AW)) u_map (
    .wide(cfg_wide), .size(size_q), .base(base_q), .idx(idx_q), .wdata(wdata_q),
    .dev_addr(cyc_addr), .be_n(cyc_be_n), .dq(cyc_dq), .lane(cyc_lane), .num_cyc(num_cyc)
  );

  extmem_rd_gather u_gather (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cap(cap), .wide(cfg_wide),
    .be_n(cyc_be_n), .lane(cyc_lane), .dq_in(mem_dq_in), .rdata(gathered)
  );

  assign last_cyc = ({1'b0, idx_q} == (num_cyc - 3'd1));

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    tm_load = 1'b0;
    tm_val  = cfg_setup;
    cap     = 1'b0;
    clr     = 1'b0;
    case (st_q)
      ST_IDLE: if (accept) begin
        clr   = 1'b1;
        idx_d = 2'd0;
        if (hit) begin
          st_d = ST_SETUP; tm_load = 1'b1; tm_val = cfg_setup;
        end else begin
          st_d = ST_RESP;
        end
      end
      ST_SETUP: if (tm_last) begin
        st_d    = wr_q ? ST_WREN : ST_RDACC;
        tm_load = 1'b1;
        tm_val  = cfg_access;
      end
      ST_RDACC: if (tm_last) begin
        cap = 1'b1;
        if (last_cyc) st_d = ST_RESP;
        else begin
          idx_d = idx_q + 2'd1; tm_load = 1'b1; tm_val = cfg_access;
        end
      end
      ST_WREN: if (tm_last) begin
        st_d = ST_WIDLE; tm_load = 1'b1; tm_val = cfg_idle;
      end
      ST_WIDLE: if (tm_last) begin
        if (last_cyc) st_d = ST_RESP;
        else begin
          st_d = ST_SETUP; idx_d = idx_q + 2'd1; tm_load = 1'b1; tm_val = cfg_setup;
        end
      end
      ST_RESP: if (rsp_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      wr_q    <= 1'b0;
      size_q  <= '0;
      base_q  <= '0;
      wdata_q <= '0;
      resp_q  <= RESP_OKAY;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (accept) begin
        wr_q    <= req_write;
        size_q  <= req_size;
        base_q  <= req_base;
        wdata_q <= req_wdata;
        resp_q  <= hit ? RESP_OKAY : RESP_ERROR;
      end
    end
  end

  logic dev_busy;
  assign dev_busy   = (st_q == ST_SETUP) || (st_q == ST_RDACC) ||
                      (st_q == ST_WREN)  || (st_q == ST_WIDLE);
  assign mem_cs_n   = !dev_busy;
  assign mem_oe_n   = (st_q != ST_RDACC);
  assign mem_we_n   = (st_q != ST_WREN);
  assign mem_dq_oe  = (st_q == ST_WREN) || (st_q == ST_WIDLE);
  assign mem_addr   = dev_busy ? cyc_addr : '0;
  assign mem_be_n   = dev_busy ? cyc_be_n : 2'b11;
  assign mem_dq_out = mem_dq_oe ? cyc_dq : 16'h0000;

  assign rsp_valid  = (st_q == ST_RESP);
  assign rsp_resp   = resp_q;
  assign rsp_rdata  = gathered;

  // Strobes are mutually exclusive (R6)
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
  // Strobes only inside chip select (R8)
  assert_strobe_in_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> !mem_cs_n);
  // Address holds across the write strobe (R5)
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));
  // Narrow device uses the low lane only (R4)
  assert_narrow_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !cfg_wide) |-> (mem_be_n == 2'b10));
  // Some lane is always enabled during a device cycle (R4)
  assert_lane_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> (mem_be_n != 2'b11));
  // Stalled response holds its fields (R10)
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_resp)));
  // No request taken while a response waits (R1)
  assert_no_accept_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // Error responses never come with device activity (R9)
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_resp == RESP_ERROR) |-> (mem_cs_n && !mem_dq_oe));
endmodule

// File: tb/sim_extmem_split_ctrl.sv
`timescale 1ns/1ps
module sim_extmem_split_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wide = 1'b0;
  logic [3:0]  cfg_setup = 4'd0, cfg_access = 4'd0, cfg_idle = 4'd0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  rsp_resp, mem_be_n;
  logic [31:0] rsp_rdata;
  logic [15:0] mem_addr, mem_dq_out, mem_dq_in;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] fb(input logic [15:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd29;
    return (t + a[15:8]) ^ 8'h5A;
  endfunction

  assign mem_dq_in = cfg_wide ? {fb(mem_addr | 16'h1), fb(mem_addr & 16'hFFFE)}
                              : {8'hEE, fb(mem_addr)};

  extmem_split_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_setup(cfg_setup),
    .cfg_access(cfg_access), .cfg_idle(cfg_idle), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_resp(rsp_resp), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Edge monitor: cumulative counts and a log of device cycles
  int n_csf = 0, n_csr = 0, n_oef = 0, lp = 0;
  logic [15:0] lg_a [256];
  logic [1:0]  lg_be [256];
  logic [15:0] lg_dq [256];
  logic pcs = 1'b1, poe = 1'b1, pwe = 1'b1;
  logic [15:0] paddr = '0;

  always @(negedge clk) begin
    if (pcs && !mem_cs_n) n_csf++;
    if (!pcs && mem_cs_n) n_csr++;
    if (poe && !mem_oe_n) n_oef++;
    if ((pwe && !mem_we_n) || (!mem_oe_n && (poe || mem_addr != paddr))) begin
      lg_a[lp % 256] = mem_addr;
      lg_be[lp % 256] = mem_be_n;
      lg_dq[lp % 256] = mem_dq_out;
      lp++;
    end
    pcs = mem_cs_n; poe = mem_oe_n; pwe = mem_we_n; paddr = mem_addr;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(input bit wr, input logic [31:0] addr, input logic [1:0] sz,
                     input logic [31:0] wd, input int hold);
    int bytes, n, step, lat, es, ea, ei, exp_lat;
    int csf0, csr0, oef0, lp0;
    bit hit;
    logic [15:0] base, a;
    logic [31:0] exp_rd;
    bytes = 1 << sz;
    hit   = addr < 32'hC000;
    n     = cfg_wide ? ((sz == 0) ? 1 : bytes / 2) : bytes;
    step  = cfg_wide ? 2 : 1;
    base  = addr[15:0] & ~16'(bytes - 1);
    es = cfg_setup + 1; ea = cfg_access + 1; ei = cfg_idle + 1;
    exp_lat = !hit ? 1 : (wr ? 1 + n * (es + ea + ei) : 1 + es + n * ea);
    exp_rd = '0;
    if (hit)
      for (int j = 0; j < bytes; j++) begin
        a = base + 16'(j);
        exp_rd[8*a[1:0] +: 8] = fb(a);
      end

    @(negedge clk);
    #1;
    csf0 = n_csf; csr0 = n_csr; oef0 = n_oef; lp0 = lp;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    req_valid = 1'b0; req_addr = 32'hDEAD_BEEF; req_wdata = ~wd;
    chk(!req_ready, "R1 ready low after accept", {31'd0, req_ready}, 32'd0);
    lat = 1;
    while (!rsp_valid && lat < 3000) begin @(negedge clk); #1; lat++; end

    chk(lat == exp_lat, wr ? "R5 write latency" : (hit ? "R6 read latency" : "R9 error latency"),
        32'(lat), 32'(exp_lat));
    chk(rsp_resp == (hit ? 2'b00 : 2'b01), "R9 response code", {30'd0, rsp_resp}, hit ? 32'd0 : 32'd1);
    if (!wr) chk(rsp_rdata == exp_rd, "R7 read data", rsp_rdata, exp_rd);
    chk(n_csf - csf0 == (hit ? 1 : 0) && n_csr - csr0 == (hit ? 1 : 0), "R8 chip select edges",
        32'(n_csf - csf0), hit ? 32'd1 : 32'd0);
    chk(lp - lp0 == (hit ? n : 0), "R2 device cycle count", 32'(lp - lp0), hit ? 32'(n) : 32'd0);
    if (!wr) chk(n_oef - oef0 == (hit ? 1 : 0), "R6 single output enable", 32'(n_oef - oef0), hit ? 32'd1 : 32'd0);
    if (hit && lp - lp0 == n)
      for (int k = 0; k < n; k++) begin
        logic [15:0] ra, ea16;
        logic [1:0] eb;
        ra = base + 16'(k * step);
        ea16 = cfg_wide ? (ra & 16'hFFFE) : ra;
        eb = !cfg_wide ? 2'b10 : ((sz == 0) ? (ra[0] ? 2'b01 : 2'b10) : 2'b00);
        chk(lg_a[(lp0 + k) % 256] == ea16, "R3 device address", {16'd0, lg_a[(lp0 + k) % 256]}, {16'd0, ea16});
        chk(lg_be[(lp0 + k) % 256] == eb, "R4 lane mask", {30'd0, lg_be[(lp0 + k) % 256]}, {30'd0, eb});
        if (wr) begin
          if (!cfg_wide)
            chk(lg_dq[(lp0 + k) % 256][7:0] == wd[8*ra[1:0] +: 8], "R4 narrow write data",
                {24'd0, lg_dq[(lp0 + k) % 256][7:0]}, {24'd0, wd[8*ra[1:0] +: 8]});
          else begin
            if (!eb[0]) chk(lg_dq[(lp0 + k) % 256][7:0] == wd[16*ra[1] +: 8], "R4 low lane write data",
                            {24'd0, lg_dq[(lp0 + k) % 256][7:0]}, {24'd0, wd[16*ra[1] +: 8]});
            if (!eb[1]) chk(lg_dq[(lp0 + k) % 256][15:8] == wd[16*ra[1] + 8 +: 8], "R4 high lane write data",
                            {24'd0, lg_dq[(lp0 + k) % 256][15:8]}, {24'd0, wd[16*ra[1] + 8 +: 8]});
          end
        end
      end

    for (int h = 0; h < hold; h++) begin
      logic [31:0] prev;
      prev = rsp_rdata;
      @(negedge clk); #1;
      chk(rsp_valid && !req_ready && rsp_rdata == prev, "R10 stalled response held",
          {30'd0, rsp_valid, req_ready}, 32'd2);
    end
    rsp_ready = 1'b1;
    @(negedge clk); #1;
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R10 response consumed", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid && req_ready,
        "R11 reset state", {26'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid, req_ready},
        32'b111001);

    for (int c = 0; c < 3; c++) begin
      cfg_setup  = (c == 0) ? 4'd0 : (c == 1) ? 4'd1 : 4'd3;
      cfg_access = (c == 0) ? 4'd0 : (c == 1) ? 4'd2 : 4'd0;
      cfg_idle   = (c == 0) ? 4'd0 : (c == 1) ? 4'd0 : 4'd2;
      for (int w = 0; w < 2; w++) begin
        cfg_wide = w[0];
        for (int s = 0; s < 3; s++)
          for (int o = 0; o < 4; o++)
            for (int d = 0; d < 2; d++) begin
              logic [31:0] ad;
              ad = 32'h0000_2A40 + 32'(c) * 32'h1000 + 32'(w * 16 + s * 4) + 32'(o);
              run(d[0], ad, 2'(s), 32'h8C4E_21F7 ^ (ad * 32'h0101_0101), (o == 3) ? 2 : 0);
            end
      end
    end

    // Map boundaries and error path (R9)
    cfg_wide = 1'b0; cfg_setup = 4'd1; cfg_access = 4'd1; cfg_idle = 4'd1;
    run(1'b0, 32'h0000_BFFC, 2'd2, 32'h0, 0);
    run(1'b0, 32'h0000_C000, 2'd2, 32'h0, 1);
    run(1'b1, 32'hFFFF_FFF0, 2'd0, 32'h1234_5678, 0);
    cfg_wide = 1'b1;
    run(1'b1, 32'h0000_C002, 2'd1, 32'hCAFE_F00D, 3);

    // Longest phases (R5, R6)
    cfg_wide = 1'b0; cfg_setup = 4'd15; cfg_access = 4'd15; cfg_idle = 4'd15;
    run(1'b1, 32'h0000_0104, 2'd2, 32'h0BAD_C0DE, 0);
    run(1'b0, 32'h0000_0104, 2'd2, 32'h0, 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule